// File: doc/BRIEF.md
# Serial Interrupt Slave Agent

This block is the peripheral-side agent on a shared, open-drain, single-wire serial interrupt bus that runs on the host clock. It watches up to fifteen local interrupt request levels and follows the host's Start, Data and Stop frames. It places each enabled level into that IRQ's fixed time slot by pulling the wire low, releasing it, and then driving it high for one recovery clock. Because the wire is open-drain, the pin is split into a sampled input, an output enable and a drive value. The pad combines them with the pull-up outside the block.

Each cycle begins when a Start pulse ends with a low-to-high edge. Every later data frame is exactly three clocks long: Sample, then Recovery, then Turn-around. The width of the Stop pulse that closes a cycle selects the bus mode for the next cycle. In continuous mode only the host may begin a cycle. In quiet mode the agent may itself ask for a cycle when one of its lines changes, by pulling the wire low for a single clock; the host then extends that pulse into a full Start pulse.

Top module: `sirq_slave_agent`

## Requirements
- R1: After reset the output enable is low and the bus is in continuous mode, so a change on a local line causes no request before the host has run a cycle.
- R2: The first clock in which the wire is seen high after a Start pulse is clock 0. Period p (1..16) has its Sample phase on clock 3p-1. Period 1 carries no IRQ, and IRQ i (1..15) uses period i+1, so IRQ15 samples on clock 47.
- R3: In the Sample phase of IRQ i the agent drives low (oe=1, out=0) only when the latched level is 0 and enable bit i is 1. Otherwise oe is 0.
- R4: In a Recovery phase the agent drives high (oe=1, out=1) exactly when it drove low on the clock before. In every Turn-around phase oe is 0.
- R5: The level of IRQ i is captured on clock 3i+1, one clock before its Sample phase. A change made on or before that clock is reported in the current cycle, and a later change is not.
- R6: A Stop pulse of 2 clocks or fewer selects quiet mode, and one of 3 clocks or more selects continuous mode. The mode changes only when a Stop pulse ends. The Stop pulse is the first low pulse after clock 49.
- R7: In continuous mode the agent never drives the wire outside the data slots.
- R8: In quiet mode, while the bus is idle, a change on an enabled line makes the agent drive the wire low (oe=1, out=0) for exactly one clock, starting within 3 clocks of the change. After that it releases the wire.
- R9: A change whose slot is still to come in the running cycle is delivered in that cycle and raises no request afterwards. A change made after its slot causes a request once the quiet-mode Stop pulse has ended.
- R10: An IRQ whose enable bit is 0 is never driven and its changes cause no request. Bit 0 of both vectors is unused.
- R11: The agent reports its levels in every cycle, whether the host or the agent began it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sirq_in | input | 1 | Sampled level of the shared wire |
| sirq_oe | output | 1 | Agent drives the wire when 1 |
| sirq_out | output | 1 | Value driven while sirq_oe is 1 |
| irq_lvl | input | NUM_IRQ+1 | Local IRQ levels, bit i for IRQ i, bit 0 unused |
| irq_en | input | NUM_IRQ+1 | Per-IRQ enable mask, bit 0 unused |

## Verification
Some rules are checked by properties on every clock. A recovery drive always follows a sample drive, and the request pulse lasts a single clock. No request is made in continuous mode, the mode moves only at the end of a Stop pulse, and at most one drive source is active. Other behaviour can only be shown by the bench's scenarios. These include the slot-to-clock mapping, the exact clock on which each level is captured, and the decoding of the Stop width into a mode. They also include whether a change before or after its slot raises a later request, and that masked lines stay silent. The bench covers these with directed corner cases and fixed-seed random cycles checked against its own slot model.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_START, ST_DATA, ST_STOPW, ST_STOPL
  } sirq_st_e;

  // last clock of the final turn-around phase
  function automatic int sirq_last_clk(input int nirq);
    return 3 * (nirq + 1) + 1;
  endfunction

  // clock one before a slot's sample phase (periods 2..nirq+1)
  function automatic logic sirq_is_latch(input int c, input int nirq);
    return (c % 3 == 1) && (c >= 4) && (c <= 3 * nirq + 1);
  endfunction

  function automatic logic sirq_is_sample(input int c, input int nirq);
    return (c % 3 == 2) && (c >= 5) && (c <= 3 * nirq + 2);
  endfunction

  function automatic logic sirq_is_recov(input int c, input int nirq);
    return (c % 3 == 0) && (c >= 6) && (c <= 3 * nirq + 3);
  endfunction

  // IRQ number whose level is captured on latch clock c
  function automatic int sirq_slot_irq(input int c);
    return (c + 2) / 3 - 1;
  endfunction

endpackage

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int NUM_IRQ   = 15,
  parameter int CW        = 6,
  parameter int WW        = 4,
  parameter int QUIET_MAX = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sirq_in,
  input  logic          want_req,
  output logic [CW-1:0] cnt,
  output logic          in_data,
  output logic          req_drive,
  output logic          quiet,
  output logic          stop_end
);
  localparam int LAST = sirq_last_clk(NUM_IRQ);
  localparam logic [WW-1:0] WMAX = {WW{1'b1}};

  sirq_st_e        st;
  logic [WW-1:0]   wcnt;

  assign in_data   = (st == ST_DATA);
  assign req_drive = (st == ST_REQ);
  assign stop_end  = (st == ST_STOPL) && sirq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      wcnt  <= '0;
      quiet <= 1'b0;
    end else begin
      case (st)
        ST_IDLE:  if (!sirq_in) st <= ST_START;
                  else if (quiet && want_req) st <= ST_REQ;
        ST_REQ:   st <= ST_START;
        ST_START: if (sirq_in) begin
                    st  <= ST_DATA;
                    cnt <= CW'(1);
                  end
        ST_DATA:  if (int'(cnt) == LAST) st <= ST_STOPW;
                  else cnt <= cnt + 1'b1;
        ST_STOPW: if (!sirq_in) begin
                    st   <= ST_STOPL;
                    wcnt <= WW'(1);
                  end
        ST_STOPL: if (sirq_in) begin
                    quiet <= (int'(wcnt) <= QUIET_MAX);
                    st    <= ST_IDLE;
                  end else if (wcnt != WMAX) begin
                    wcnt <= wcnt + 1'b1;
                  end
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assert_mode_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_end |=> $stable(quiet));
  assert_no_req_continuous_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet |-> !req_drive);
  assert_req_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_drive |=> !req_drive);

endmodule

// File: rtl/sirq_chg.sv
module sirq_chg #(
  parameter int NUM_IRQ = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_IRQ:0] irq_lvl,
  input  logic [NUM_IRQ:0] irq_en,
  input  logic [NUM_IRQ:0] clr_vec,
  output logic             pend_any
);
  localparam logic [NUM_IRQ:0] BIT0 = {{NUM_IRQ{1'b0}}, 1'b1};

  logic [NUM_IRQ:0] masked, prev, pend, chg;
  logic             chg_any;

  assign masked   = irq_lvl | ~irq_en;   // disabled lines read as idle-high
  assign chg      = (masked ^ prev) & ~BIT0;
  assign chg_any  = |chg;
  assign pend_any = |pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev <= '1;
      pend <= '0;
    end else begin
      prev <= masked;
      pend <= (pend | chg) & ~clr_vec & ~BIT0;
    end
  end

  assert_pend_from_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_any) |-> $past(chg_any));

endmodule

// File: rtl/sirq_drv.sv
module sirq_drv
  import sirq_pkg::*;
#(
  parameter int NUM_IRQ = 15,
  parameter int CW      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cnt,
  input  logic             in_data,
  input  logic [NUM_IRQ:0] irq_lvl,
  input  logic [NUM_IRQ:0] irq_en,
  output logic [NUM_IRQ:0] clr_vec,
  output logic             drive_low,
  output logic             drive_high
);
  logic latch, lat_sel, lat_q, drove_q;

  always_comb begin
    latch   = in_data && sirq_is_latch(int'(cnt), NUM_IRQ);
    lat_sel = 1'b1;
    clr_vec = '0;
    for (int i = 0; i <= NUM_IRQ; i++) begin
      if (latch && i > 0 && sirq_slot_irq(int'(cnt)) == i) begin
        lat_sel    = irq_lvl[i] | ~irq_en[i];
        clr_vec[i] = 1'b1;
      end
    end
  end

  assign drive_low  = in_data && sirq_is_sample(int'(cnt), NUM_IRQ) && !lat_q;
  assign drive_high = in_data && sirq_is_recov(int'(cnt), NUM_IRQ) && drove_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q   <= 1'b1;
      drove_q <= 1'b0;
    end else begin
      if (latch) lat_q <= lat_sel;
      drove_q <= drive_low;
    end
  end

  assert_high_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drive_high |-> $past(drive_low));
  assert_low_single_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |=> !drive_low);

endmodule

// File: rtl/sirq_slave_agent.sv
module sirq_slave_agent #(
  parameter int NUM_IRQ   = 15,
  parameter int QUIET_MAX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sirq_in,
  output logic             sirq_oe,
  output logic             sirq_out,
  input  logic [NUM_IRQ:0] irq_lvl,
  input  logic [NUM_IRQ:0] irq_en
);
  localparam int LAST = sirq_pkg::sirq_last_clk(NUM_IRQ);
  localparam int CW   = $clog2(LAST + 1);
  localparam int WW   = $clog2(QUIET_MAX + 2) + 1;

  logic [CW-1:0]    cnt;
  logic             in_data, req_drive, quiet, stop_end, pend_any;
  logic             drive_low, drive_high;
  logic [NUM_IRQ:0] clr_vec;

  sirq_seq #(.NUM_IRQ(NUM_IRQ), .CW(CW), .WW(WW), .QUIET_MAX(QUIET_MAX)) u_seq (
    .clk, .rst_n, .sirq_in, .want_req(pend_any), .cnt, .in_data,
    .req_drive, .quiet, .stop_end
  );

  sirq_chg #(.NUM_IRQ(NUM_IRQ)) u_chg (
    .clk, .rst_n, .irq_lvl, .irq_en, .clr_vec, .pend_any
  );

  sirq_drv #(.NUM_IRQ(NUM_IRQ), .CW(CW)) u_drv (
    .clk, .rst_n, .cnt, .in_data, .irq_lvl, .irq_en, .clr_vec,
    .drive_low, .drive_high
  );

  assign sirq_oe  = req_drive | drive_low | drive_high;
  assign sirq_out = drive_high;

  assert_one_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_drive, drive_low, drive_high}));
  assert_quiet_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_data && !quiet) |-> !sirq_oe);
  assert_stop_unused_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_end |-> !sirq_oe);

endmodule

// File: tb/sirq_slave_agent_bench.sv
module sirq_slave_agent_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_low = 1'b0;
  logic [15:0] lvl = 16'hFFFF;
  logic [15:0] en  = 16'hFFFE;
  logic        sirq_oe, sirq_out, bus;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #4 clk = ~clk;   // 125 MHz

  assign bus = host_low ? 1'b0 : (sirq_oe ? sirq_out : 1'b1);

  sirq_slave_agent u_sirq_slave_agent (
    .clk(clk), .rst_n(rst_n), .sirq_in(bus), .sirq_oe(sirq_oe),
    .sirq_out(sirq_out), .irq_lvl(lvl), .irq_en(en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected {oe,out} on clock k; code 0 = released, 2 = low, 3 = high
  function automatic int exp_code(input int k, input logic [15:0] lv, input logic [15:0] e);
    int p;
    if (k % 3 == 2) p = (k + 1) / 3;
    else if (k % 3 == 0) p = k / 3;
    else return 0;
    if (p < 2 || p > 16) return 0;
    if (e[p-1] && !lv[p-1]) return (k % 3 == 2) ? 2 : 3;
    return 0;
  endfunction

  task automatic watch_quiet(input int n, input string req);
    int hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sirq_oe) hits++;
    end
    chk(hits == 0, req, hits, 0);
  endtask

  task automatic wait_req(input int maxc, input string req);
    int waited = 0;
    bit seen = 0;
    for (int i = 0; i < maxc && !seen; i++) begin
      @(negedge clk);
      waited++;
      if (sirq_oe && !sirq_out) seen = 1;
    end
    chk(seen && waited <= 3, req, waited, 3);
  endtask

  // called at a negedge; agent_st means the agent's request is on the wire now
  task automatic run_cycle(input int start_len, input int stop_len, input bit agent_st,
                           input bit rnd, input int chg_clk, input int chg_idx,
                           input bit chg_val, input string tag);
    logic [15:0] lv_s, en_s, lv_e;
    int bad = 0, bad_k = -1, act = 0, expc = 0, got;
    host_low = 1'b1;
    @(negedge clk);
    if (agent_st) chk(!sirq_oe, "R8 request released after one clock", sirq_oe, 0);
    if (rnd) begin
      lvl = 16'($urandom);
      en  = 16'($urandom);
    end
    repeat (start_len - 1) @(negedge clk);
    host_low = 1'b0;
    lv_s = lvl; en_s = en;
    @(posedge clk);
    for (int k = 1; k <= 49; k++) begin
      @(negedge clk);
      lv_e = lv_s;
      if (chg_idx > 0 && chg_clk <= 3 * chg_idx + 1) lv_e[chg_idx] = chg_val;
      got = {30'd0, sirq_oe, sirq_oe & sirq_out};
      if (got != exp_code(k, lv_e, en_s)) begin
        bad++;
        if (bad_k < 0) begin bad_k = k; act = got; expc = exp_code(k, lv_e, en_s); end
      end
      if (k == chg_clk && chg_idx > 0) lvl[chg_idx] = chg_val;
    end
    if (bad != 0) $display("  %s first mismatch at clock %0d", tag, bad_k);
    chk(bad == 0, tag, act, expc);
    @(negedge clk);
    host_low = 1'b1;
    repeat (stop_len) @(negedge clk);
    host_low = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk(!sirq_oe, "R1 oe low in reset", sirq_oe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sirq_oe, "R1 oe low after reset", sirq_oe, 0);
    lvl[3] = 1'b0;
    watch_quiet(10, "R1 no request before first host cycle");

    // host-started cycle, continuous stop
    run_cycle(4, 3, 0, 0, 0, 0, 0, "R2 R3 R4 R11 host cycle slot map");
    lvl[5] = 1'b0;
    watch_quiet(10, "R7 continuous mode, no request on change");

    // long start, quiet stop; pending from IRQ5 is delivered in this cycle
    run_cycle(8, 2, 0, 0, 0, 0, 0, "R3 R4 eight clock start");
    watch_quiet(10, "R9 delivered change raises no request");

    // quiet mode request by agent
    lvl[7] = 1'b0;
    wait_req(6, "R8 request after change in quiet mode");
    run_cycle(4, 2, 1, 0, 0, 0, 0, "R11 agent started cycle reports levels");

    // mid-cycle change before its slot: delivered, no request after
    run_cycle(4, 2, 0, 0, 10, 15, 0, "R5 R9 change before IRQ15 slot");
    watch_quiet(10, "R9 no request after change delivered in cycle");

    // change after its slot: request after stop
    run_cycle(5, 2, 0, 0, 30, 1, 0, "R5 change after IRQ1 slot not shown");
    wait_req(6, "R9 late change requests after stop");
    run_cycle(4, 2, 1, 0, 0, 0, 0, "R9 late change delivered next cycle");

    // masked line
    en[9] = 1'b0;
    @(negedge clk);
    lvl[9] = 1'b0;
    watch_quiet(10, "R10 masked change raises no request");
    run_cycle(4, 2, 0, 0, 0, 0, 0, "R10 masked IRQ9 not driven");

    // capture clock boundary for IRQ4 (clock 13)
    run_cycle(4, 2, 0, 0, 13, 4, 0, "R5 change on capture clock is shown");
    watch_quiet(8, "R5 boundary change delivered, no request");
    run_cycle(4, 3, 0, 0, 14, 4, 1, "R5 change after capture clock not shown");
    watch_quiet(8, "R6 stop of three selects continuous");

    // stop width decoding: 1 clock is quiet
    run_cycle(4, 1, 0, 0, 0, 0, 0, "R6 short stop cycle");
    lvl[12] = ~lvl[12];
    en[12]  = 1'b1;
    wait_req(6, "R6 one clock stop selects quiet");
    run_cycle(4, 5, 1, 0, 0, 0, 0, "R11 agent cycle before long stop");
    lvl[12] = ~lvl[12];
    watch_quiet(8, "R6 five clock stop selects continuous");

    // random cycles with fixed seed
    for (int n = 0; n < 30; n++) begin
      int sl, st;
      sl = ($urandom % 5) + 4;
      st = ($urandom % 2) + 2;
      run_cycle(sl, st, 0, 1, 0, 0, 0, "R3 R4 R10 random cycle");
    end
    watch_quiet(8, "R9 random cycles leave nothing pending");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule